// File: doc/BRIEF.md
# Open-Drain Reset Pulse Controller

This block owns one shared active-low, open-drain reset pin. The pin has two uses. Software can start a timed low pulse that other devices on the board see as a reset. When the block is not pulsing, the pin serves as an input, and an externally applied low puts the device's configuration back to its power-on state.

The block holds a small register set: a configuration register, a second interrupt-mask register, a DAC data register and a few value-memory words. A write that sets the pulse-request bit in the configuration register starts the pulse, but only if the pin-output enable bit in the mask register is set. A prescaled timer measures the pulse, rounded up so that it always meets the 20 ms minimum. When the pulse ends, the request bit clears itself.

An input reset happens when the synchronized pin stays low for a programmable number of cycles. It emits a one-cycle strobe to the rest of the device. It restores the configuration, mask and DAC registers and leaves the value-memory words as they were. The block ignores the low it drives itself.

Top module: `rstpin_ctrl`

## Requirements
- R1: After reset, register 0 (configuration) reads 0x08 and registers 1 (mask) and 2 (DAC) read 0x00. `pin_oe` and `regs_rst_o` are low.
- R2: With mask bit 7 set, a write to register 0 with bit 4 set raises `pin_oe` from the next cycle. `pin_oe` stays high for exactly TICKS*TICK_DIV cycles, where TICKS = ceil(ceil(CLK_HZ*MIN_PULSE_US/1e6)/TICK_DIV), so the pulse is never shorter than MIN_PULSE_US.
- R3: Register 0 bit 4 reads 1 for the whole pulse. It reads 0 from the first cycle in which `pin_oe` is low again, with no software write.
- R4: With mask bit 7 clear, writing register 0 with bit 4 set drives no pulse and stores bit 4 as 0. The other bits are written normally.
- R5: During a pulse, writing bit 4 as 1 neither restarts nor extends the pulse, and writing it as 0 does not cut the pulse short. The other configuration bits still take the written value.
- R6: When `pin_oe` is low and `pin_in` is low for at least FILT_CYCLES consecutive synchronized samples, `regs_rst_o` pulses for exactly one cycle. A single low period gives only one strobe.
- R7: A low on `pin_in` that is shorter than FILT_CYCLES samples produces no strobe and changes no register.
- R8: An input reset returns registers 0, 1 and 2 to their R1 values. The value-memory words at addresses 4 to 7 keep their contents.
- R9: The block's own pulse, seen back on `pin_in` through the shared wire, never causes `regs_rst_o`. This includes the synchronizer delay after the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| pin_in | input | 1 | Level sensed on the reset pin |
| pin_oe | output | 1 | 1 pulls the pin low, 0 releases it |
| regs_rst_o | output | 1 | One-cycle strobe that resets the device register file |

## Verification
The bench loops the open-drain pin back, so the block's own pulse appears on `pin_in`. A design that forgets to mask its own drive, or the synchronizer tail after release, would reset itself at the end of every pulse. Pulse lengths are measured cycle by cycle against a rounded-up tick count chosen to leave a remainder, which exposes an off-by-one pulse or truncating division. Writes made in the middle of a pulse check that the pulse is neither restarted nor shortened. A low held one sample short of the filter length, followed by a long low, separates a design whose filter threshold is off by one. The long low also checks that the DAC register is cleared while the value words are kept.

// File: rtl/rstpin_pkg.sv
// Package: shared constants and helpers for the reset pin controller.
// Assumes 8-bit-or-wider registers; the bit positions below are fixed.
package rstpin_pkg;

    // Register addresses decoded by the register file
    localparam int unsigned ADDR_CFG   = 0;
    localparam int unsigned ADDR_MASK  = 1;
    localparam int unsigned ADDR_DAC   = 2;

    // Bit positions whose meaning the controller depends on
    localparam int unsigned CFG_PULSE_BIT = 4;
    localparam int unsigned MASK_OUT_EN_BIT = 7;

    // Power-on defaults
    localparam logic [7:0] CFG_DEFAULT  = 8'h08;
    localparam logic [7:0] MASK_DEFAULT = 8'h00;
    localparam logic [7:0] DAC_DEFAULT  = 8'h00;

    // Number of input synchronizer stages
    localparam int unsigned SYNC_STAGES = 2;

    // Pulse timer state
    typedef enum logic {
        PT_IDLE  = 1'b0,
        PT_DRIVE = 1'b1
    } pulse_state_t;

    // Integer division rounded up
    function automatic longint ceil_div(input longint num, input longint den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/rstpin_prescaler.sv
// Module: free-running divider that emits a one-cycle tick every DIV cycles
// while run is high. A clear restarts the count so the first tick comes
// exactly DIV cycles after the clear.
module rstpin_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [CW-1:0] cnt_q;

            // Count cycles modulo DIV while running
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear) begin
                    cnt_q <= '0;
                end else if (run) begin
                    if (cnt_q == CW'(DIV - 1)) begin
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            // Tick on the last count of each period
            always_comb begin
                tick = run && (cnt_q == CW'(DIV - 1));
            end
        end else begin : g_nodiv
            // Division by one: every running cycle is a tick
            always_comb begin
                tick = run && !clear;
            end
        end
    endgenerate

endmodule

// File: rtl/rstpin_pulse_timer.sv
// Module: times the output pulse. A start in an idle cycle makes active high
// from the next cycle for exactly TICKS*DIV cycles; done is high in the last
// active cycle. Starts while active are ignored by construction of the
// caller (start is only raised when idle).
module rstpin_pulse_timer #(
    parameter int TICKS = 1000,
    parameter int DIV   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    import rstpin_pkg::*;

    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

    pulse_state_t  state_q;
    logic [TW-1:0] tick_cnt_q;
    logic          tick;
    logic          last_tick;

    rstpin_prescaler #(
        .DIV (DIV)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (state_q == PT_DRIVE),
        .tick  (tick)
    );

    // Detect the tick that completes the pulse
    always_comb begin
        last_tick = tick && (tick_cnt_q == TW'(TICKS - 1));
    end

    // Pulse state and tick counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PT_IDLE;
            tick_cnt_q <= '0;
        end else begin
            case (state_q)
                PT_IDLE: begin
                    if (start) begin
                        state_q    <= PT_DRIVE;
                        tick_cnt_q <= '0;
                    end
                end
                PT_DRIVE: begin
                    if (last_tick) begin
                        state_q    <= PT_IDLE;
                        tick_cnt_q <= '0;
                    end else if (tick) begin
                        tick_cnt_q <= tick_cnt_q + 1'b1;
                    end
                end
                default: state_q <= PT_IDLE;
            endcase
        end
    end

    // Outputs derived from the state
    always_comb begin
        active = (state_q == PT_DRIVE);
        done   = (state_q == PT_DRIVE) && last_tick;
    end

endmodule

// File: rtl/rstpin_in_filter.sv
// Module: synchronizes the pin level and accepts an external reset once the
// synchronized level has been low for FILT_CYCLES consecutive samples.
// While ignore is high (own pulse plus synchronizer tail) nothing is counted.
// One strobe per low period.
module rstpin_in_filter #(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic ignore,
    output logic strobe
);
    import rstpin_pkg::*;

    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;
    logic                   taken_q;
    logic                   strobe_q;
    logic                   pin_low;

    // Synchronizer chain, reset to the released (high) level
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[s] <= 1'b1;
                end else if (s == 0) begin
                    sync_q[s] <= pin_in;
                end else begin
                    sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    always_comb begin
        pin_low = !sync_q[SYNC_STAGES-1];
    end

    // Count consecutive low samples and fire once per low period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            taken_q   <= 1'b0;
            strobe_q  <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (ignore || !pin_low) begin
                low_cnt_q <= '0;
                taken_q   <= 1'b0;
            end else if (!taken_q) begin
                if (low_cnt_q == CW'(FILT_CYCLES - 1)) begin
                    strobe_q <= 1'b1;
                    taken_q  <= 1'b1;
                    low_cnt_q <= '0;
                end else begin
                    low_cnt_q <= low_cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        strobe = strobe_q;
    end

endmodule

// File: rtl/rstpin_regs.sv
// Module: register file seen through the write/read port. Holds the
// configuration, mask and DAC registers (restored by the reset strobe) and
// VR_DEPTH value words at the top of the address space (kept across it).
// Decides when a write starts a pulse and keeps the self-clearing bit.
module rstpin_regs #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 8,
    parameter int VR_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rst_strobe,
    input  logic              pulse_active,
    input  logic              pulse_done,
    output logic              pulse_start,
    output logic              out_en,
    output logic              pulse_bit
);
    import rstpin_pkg::*;

    localparam int VR_BASE = (1 << ADDR_W) - VR_DEPTH;

    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] dac_q;
    logic [DATA_W-1:0] vr_q [VR_DEPTH];
    logic [DATA_W-1:0] cfg_next;
    logic              wr_cfg;

    // Decode a configuration write and whether it launches a pulse
    always_comb begin
        wr_cfg      = we && (addr == ADDR_W'(ADDR_CFG));
        pulse_start = wr_cfg && wdata[CFG_PULSE_BIT] && mask_q[MASK_OUT_EN_BIT]
                      && !pulse_active && !rst_strobe;
        cfg_next    = wdata;
        cfg_next[CFG_PULSE_BIT] = cfg_q[CFG_PULSE_BIT] | pulse_start;
    end

    // Configuration register with the self-clearing pulse bit
    always_ff @(posedge clk) begin
        if (!rst_n || rst_strobe) begin
            cfg_q <= DATA_W'(CFG_DEFAULT);
        end else begin
            if (wr_cfg) begin
                cfg_q <= cfg_next;
            end
            if (pulse_done) begin
                cfg_q[CFG_PULSE_BIT] <= 1'b0;
            end
        end
    end

    // Mask and DAC registers, both restored by the reset strobe
    always_ff @(posedge clk) begin
        if (!rst_n || rst_strobe) begin
            mask_q <= DATA_W'(MASK_DEFAULT);
            dac_q  <= DATA_W'(DAC_DEFAULT);
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_MASK)) mask_q <= wdata;
            if (addr == ADDR_W'(ADDR_DAC))  dac_q  <= wdata;
        end
    end

    // Value words: cleared only by the block reset
    generate
        for (genvar v = 0; v < VR_DEPTH; v++) begin : g_vr
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vr_q[v] <= '0;
                end else if (we && (addr == ADDR_W'(VR_BASE + v))) begin
                    vr_q[v] <= wdata;
                end
            end
        end
    endgenerate

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CFG))  rdata = cfg_q;
        if (addr == ADDR_W'(ADDR_MASK)) rdata = mask_q;
        if (addr == ADDR_W'(ADDR_DAC))  rdata = dac_q;
        for (int v = 0; v < VR_DEPTH; v++) begin
            if (addr == ADDR_W'(VR_BASE + v)) rdata = vr_q[v];
        end
    end

    always_comb begin
        out_en    = mask_q[MASK_OUT_EN_BIT];
        pulse_bit = cfg_q[CFG_PULSE_BIT];
    end

endmodule

// File: rtl/rstpin_ctrl.sv
// Module: top of the reset pin controller. Ties the register file, pulse
// timer and input filter together and masks the block's own drive from the
// input path, including the synchronizer tail after release.
// Assumes pin_in reflects the shared wire (low whenever pin_oe is high).
module rstpin_ctrl #(
    parameter int ADDR_W       = 3,
    parameter int DATA_W       = 8,
    parameter int VR_DEPTH     = 4,
    parameter int CLK_HZ       = 50_000_000,
    parameter int MIN_PULSE_US = 20_000,
    parameter int TICK_DIV     = 1000,
    parameter int FILT_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pin_in,
    output logic              pin_oe,
    output logic              regs_rst_o
);
    import rstpin_pkg::*;

    localparam longint MIN_CYC   = ceil_div(longint'(CLK_HZ) * longint'(MIN_PULSE_US), 64'd1_000_000);
    localparam int     TICKS     = int'(ceil_div(MIN_CYC, longint'(TICK_DIV)));
    localparam int     PULSE_CYC = TICKS * TICK_DIV;
    localparam int     GW        = $clog2(SYNC_STAGES + 1);

    logic          pulse_start;
    logic          pulse_active;
    logic          pulse_done;
    logic          out_en;
    logic          pulse_bit;
    logic          in_ignore;
    logic [GW-1:0] guard_q;

    rstpin_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VR_DEPTH (VR_DEPTH)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (reg_we),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .rst_strobe   (regs_rst_o),
        .pulse_active (pulse_active),
        .pulse_done   (pulse_done),
        .pulse_start  (pulse_start),
        .out_en       (out_en),
        .pulse_bit    (pulse_bit)
    );

    rstpin_pulse_timer #(
        .TICKS (TICKS),
        .DIV   (TICK_DIV)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pulse_start),
        .active (pulse_active),
        .done   (pulse_done)
    );

    // Hold the input off for the synchronizer depth after release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else if (pulse_done) begin
            guard_q <= GW'(SYNC_STAGES);
        end else if (guard_q != '0) begin
            guard_q <= guard_q - 1'b1;
        end
    end

    // Input is ignored while starting, driving, or draining the synchronizer
    always_comb begin
        in_ignore = pulse_start || pulse_active || (guard_q != '0);
    end

    rstpin_in_filter #(
        .FILT_CYCLES (FILT_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .ignore (in_ignore),
        .strobe (regs_rst_o)
    );

    always_comb begin
        pin_oe = pulse_active;
    end

endmodule

// File: rtl/rstpin_ctrl_chk.sv
// Checker: temporal properties of the reset pin controller, bound to the top.
module rstpin_ctrl_chk #(
    parameter int PULSE_CYC = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic pin_oe,
    input logic regs_rst_o,
    input logic out_en,
    input logic pulse_bit
);
    int hi_cnt;

    // Length of the current high run of pin_oe
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= 0;
        else if (pin_oe) hi_cnt <= hi_cnt + 1;
        else hi_cnt <= 0;
    end

    assert_out_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe) |-> $past(out_en));

    assert_len_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (hi_cnt < PULSE_CYC));

    assert_len_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_oe) |-> (hi_cnt == PULSE_CYC));

    assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> pulse_bit);

    assert_bit_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_oe) |-> !pulse_bit);

    assert_no_self_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        regs_rst_o |-> !pin_oe);

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        regs_rst_o |=> !regs_rst_o);

endmodule

bind rstpin_ctrl rstpin_ctrl_chk #(
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_oe     (pin_oe),
    .regs_rst_o (regs_rst_o),
    .out_en     (out_en),
    .pulse_bit  (pulse_bit)
);

// File: tb/rstpin_ctrl_bench.sv
// Bench: scoreboard of expected pulse lengths fed by the driver and checked
// by a monitor; register contents and reset strobes checked directly.
module rstpin_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CLK_HZ = 200_000;
    localparam int MIN_US = 20_000;
    localparam int DIV    = 7;
    localparam int FILT   = 8;
    // Expected pulse length from R2: ceil(ceil(4000)/7)=572 ticks -> 4004 cycles
    localparam int EXP_MIN   = (CLK_HZ / 1000 * MIN_US + 999) / 1000;
    localparam int EXP_PULSE = ((EXP_MIN + DIV - 1) / DIV) * DIV;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              pin_oe;
    logic              regs_rst_o;
    logic              ext_low = 1'b0;
    logic              pin_in;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    int run_len = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Shared open-drain wire: low if either side pulls
    assign pin_in = ~(pin_oe | ext_low);

    rstpin_ctrl #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .VR_DEPTH     (4),
        .CLK_HZ       (CLK_HZ),
        .MIN_PULSE_US (MIN_US),
        .TICK_DIV     (DIV),
        .FILT_CYCLES  (FILT)
    ) u_rstpin_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .regs_rst_o (regs_rst_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        check(reg_rdata == DATA_W'(exp), tag, int'(reg_rdata), exp);
    endtask

    // Monitor: measure pin_oe high runs and compare against the scoreboard
    always @(negedge clk) begin
        if (regs_rst_o) strobes++;
        if (pin_oe) begin
            run_len++;
        end else if (run_len > 0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected pulse", run_len, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(run_len == e, "R2 pulse length", run_len, e);
            end
            run_len = 0;
        end
    end

    // Watchdog
    initial begin
        repeat (200_000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_check(0, 8'h08, "R1 cfg default");
        rd_check(1, 8'h00, "R1 mask default");
        rd_check(2, 8'h00, "R1 dac default");
        check(pin_oe == 1'b0 && regs_rst_o == 1'b0, "R1 outputs idle", int'(pin_oe), 0);

        // R4: output disabled by mask bit 7
        wr(0, 8'h18);
        repeat (50) @(negedge clk);
        check(pin_oe == 1'b0, "R4 no drive", int'(pin_oe), 0);
        rd_check(0, 8'h08, "R4 bit4 stays 0");

        // Setup for pulses and survival checks
        wr(1, 8'h80);
        wr(2, 8'h5A);
        for (int i = 4; i < 8; i++) wr(i, 8'h11 * (i - 3));

        // R2/R3/R5: pulse with mid-pulse writes
        exp_q.push_back(EXP_PULSE);
        wr(0, 8'h19);
        check(pin_oe == 1'b1, "R2 pulse started", int'(pin_oe), 1);
        rd_check(0, 8'h19, "R3 bit4 set during pulse");
        repeat (1000) @(negedge clk);
        wr(0, 8'h01);
        rd_check(0, 8'h11, "R5 clear write ignored for bit4");
        repeat (1000) @(negedge clk);
        wr(0, 8'h11);
        reg_addr = ADDR_W'(0);
        while (pin_oe) @(negedge clk);
        #1;
        check(reg_rdata == 8'h01, "R3 self clear at release", int'(reg_rdata), 8'h01);
        repeat (20) @(negedge clk);
        check(strobes == 0, "R9 own pulse not a reset", strobes, 0);
        rd_check(2, 8'h5A, "R9 dac kept after own pulse");

        // R7: short external low
        @(negedge clk); ext_low = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        ext_low = 1'b0;
        repeat (20) @(negedge clk);
        check(strobes == 0, "R7 short low ignored", strobes, 0);
        rd_check(2, 8'h5A, "R7 dac unchanged");

        // R6/R8: long external low
        @(negedge clk); ext_low = 1'b1;
        repeat (FILT + 20) @(negedge clk);
        ext_low = 1'b0;
        repeat (10) @(negedge clk);
        check(strobes == 1, "R6 one strobe per low", strobes, 1);
        rd_check(0, 8'h08, "R8 cfg restored");
        rd_check(1, 8'h00, "R8 mask restored");
        rd_check(2, 8'h00, "R8 dac restored");
        for (int i = 4; i < 8; i++) rd_check(i, 8'h11 * (i - 3), "R8 value word kept");

        // R2 second pulse after re-enabling
        wr(1, 8'h80);
        exp_q.push_back(EXP_PULSE);
        wr(0, 8'h10);
        while (pin_oe) @(negedge clk);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);
        check(strobes == 1, "R9 no strobe from second pulse", strobes, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule